// File: doc/BRIEF.md
# Programmable Logic Reset Sequencer

This block wipes the previous configuration of a programmable-logic fabric before fresh configuration data is streamed in. It owns the fabric's active-low program line (`prog_n_o`, where 1 means released and 0 means the fabric is held in clear) and watches the fabric's INIT status line. A single start request makes it run the whole handshake on its own. First it releases the program line and makes sure INIT is high. Then it pulls the program line low and polls until INIT falls. Finally it releases the line again and waits for INIT to rise, which marks the end of fabric initialisation.

All timing is counted in ticks of a one-microsecond strobe (`us_tick_i`), so the same block works at any system clock. The poll limit, the poll spacing and the wait timeout are parameters. INIT is asynchronous to the sequencer's clock, so it passes through a two-flop synchroniser before any decision or edge detection. The outcome is reported as a one-cycle `done_o` pulse together with a two-bit result code. The code is held until the next accepted start. `clr_sticky_o` pulses whenever the surrounding logic should clear its sticky interrupt status bits.

The states are IDLE, CHECK, RISE1, PULSE and RISE2, with these transitions:
- IDLE→CHECK on start.
- CHECK→PULSE when INIT is already high; this skips the wait for an edge.
- CHECK→RISE1 when INIT is low.
- RISE1→PULSE on a rising edge of INIT.
- RISE1→IDLE on timeout.
- PULSE→RISE2 when a poll sees INIT low.
- PULSE→IDLE when the last poll still sees INIT high.
- RISE2→IDLE on a rising edge of INIT (success) or on timeout.

Top module: `pl_reset_seq`

## Requirements
- R1: While reset is asserted and just after it, `prog_n_o`=1, `busy_o`=0, `done_o`=0, `clr_sticky_o`=0 and `err_o`=0.
- R2: A start seen in IDLE moves to CHECK at that edge. In the next cycle `busy_o`=1, `err_o`=0 and `clr_sticky_o`=1. A start while busy is ignored: the run's result, duration and number of `done_o` pulses are unchanged.
- R3: INIT is sampled through a two-flop synchroniser. In CHECK, if the synchronised INIT is high, the sequencer enters PULSE on the next edge, so exactly one busy cycle has `prog_n_o`=1. If it is low, the sequencer waits in RISE1 for a rising edge.
- R4: In PULSE, `prog_n_o`=0. INIT is polled once every POLL_GAP_US ticks, the first poll coming POLL_GAP_US ticks after PULSE is entered. The first poll that sees INIT low releases the line and moves to RISE2.
- R5: If the POLL_LIMIT-th poll still sees INIT high, the run ends with code 1 (INIT stuck). `prog_n_o` will then have been low for exactly POLL_LIMIT*POLL_GAP_US ticks.
- R6: In RISE2, a rising edge of INIT ends the run with code 0.
- R7: A wait in RISE1 or RISE2 that lasts RISE_TIMEOUT_US ticks without an INIT rise ends the run. The code is 2 for RISE1 and 3 for RISE2. RISE1 plus CHECK then spans RISE_TIMEOUT_US+1 busy cycles at one tick per cycle.
- R8: `clr_sticky_o` pulses for one cycle after three events: the start, entry to RISE2, and a successful final rise. A successful run thus gives 3 pulses, a code-3 run 2, and a code-1 or code-2 run 1.
- R9: `done_o` is a one-cycle pulse in the first IDLE cycle after a run ends, with `err_o` valid at the same time. `err_o` then holds until the next accepted start.
- R10: The timers advance only on `us_tick_i`. With no ticks a wait never times out, and the sequencer stays busy with the program line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on only in IDLE |
| init_i | input | 1 | Fabric INIT status level, asynchronous |
| us_tick_i | input | 1 | One-cycle strobe each microsecond |
| prog_n_o | output | 1 | Active-low program line (0 = clear fabric) |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 2 | Result: 0 ok, 1 INIT stuck high, 2 first wait timeout, 3 final wait timeout |
| clr_sticky_o | output | 1 | One-cycle request to clear sticky interrupt status |

## Verification
`prog_n_o` and `busy_o` follow the state register with no added delay. `done_o`, `err_o` and `clr_sticky_o` appear one cycle after the edge that takes the transition. A change on INIT takes two edges to reach the decision logic, and one further edge before a rise is seen. The bench keeps the tick high every cycle, models the fabric at falling edges, and counts busy, program-low and pulse cycles at falling edges. It compares these counts with totals worked out from the latencies above: for example 5 program-low cycles when INIT drops three cycles into PULSE, and 501 busy cycles for a stuck INIT. Directed steps then cover the ignored start, the held result and a stalled tick.

// File: rtl/plrs_pkg.sv
package plrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_RISE1,
        S_PULSE,
        S_RISE2
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_STUCK    = 2'd1,
        ERR_TO_FIRST = 2'd2,
        ERR_TO_FINAL = 2'd3
    } seq_err_t;

endpackage

// File: rtl/plrs_init_sync.sv
module plrs_init_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

    // R3: an edge report lasts one cycle only
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/plrs_tick_timer.sv
module plrs_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: every phase change restarts the interval count
    p_timer_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R10: without a tick the count cannot move
    p_timer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/pl_reset_seq.sv
module pl_reset_seq
    import plrs_pkg::*;
#(
    parameter int POLL_LIMIT      = 100,
    parameter int POLL_GAP_US     = 5,
    parameter int RISE_TIMEOUT_US = 1000000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       init_i,
    input  logic       us_tick_i,
    output logic       prog_n_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] err_o,
    output logic       clr_sticky_o
);
    localparam int TMAX = (RISE_TIMEOUT_US > POLL_GAP_US) ? RISE_TIMEOUT_US : POLL_GAP_US;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(POLL_LIMIT + 1);
    localparam logic [TW-1:0] TO_LAST   = TW'(RISE_TIMEOUT_US - 1);
    localparam logic [TW-1:0] GAP_LAST  = TW'(POLL_GAP_US - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);
    localparam logic [PW-1:0] POLL_CAP  = PW'(POLL_LIMIT);

    seq_state_t    state_q, state_n;
    seq_err_t      err_q, fin_err;
    logic          done_q, clr_q;
    logic          fin, clr_req, poll_due, start_take;
    logic          init_lvl, init_rise;
    logic          tmr_clr;
    logic [TW-1:0] tmr_cnt;
    logic [PW-1:0] polls_q;

    plrs_init_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (init_i),
        .level_o (init_lvl),
        .rise_o  (init_rise)
    );

    assign tmr_clr = (state_n != state_q) | poll_due;

    plrs_tick_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (us_tick_i),
        .cnt   (tmr_cnt)
    );

    // next-state and transition events
    always_comb begin
        state_n    = state_q;
        fin        = 1'b0;
        fin_err    = ERR_NONE;
        clr_req    = 1'b0;
        poll_due   = 1'b0;
        start_take = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    start_take = 1'b1;
                    clr_req    = 1'b1;
                    state_n    = S_CHECK;
                end
            end
            S_CHECK: begin
                state_n = init_lvl ? S_PULSE : S_RISE1;
            end
            S_RISE1: begin
                if (init_rise) begin
                    state_n = S_PULSE;
                end else if (us_tick_i && (tmr_cnt == TO_LAST)) begin
                    fin     = 1'b1;
                    fin_err = ERR_TO_FIRST;
                    state_n = S_IDLE;
                end
            end
            S_PULSE: begin
                if (us_tick_i && (tmr_cnt == GAP_LAST)) begin
                    poll_due = 1'b1;
                    if (!init_lvl) begin
                        clr_req = 1'b1;
                        state_n = S_RISE2;
                    end else if (polls_q == POLL_LAST) begin
                        fin     = 1'b1;
                        fin_err = ERR_STUCK;
                        state_n = S_IDLE;
                    end
                end
            end
            S_RISE2: begin
                if (init_rise) begin
                    fin     = 1'b1;
                    fin_err = ERR_NONE;
                    clr_req = 1'b1;
                    state_n = S_IDLE;
                end else if (us_tick_i && (tmr_cnt == TO_LAST)) begin
                    fin     = 1'b1;
                    fin_err = ERR_TO_FINAL;
                    state_n = S_IDLE;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // poll counter, live only in PULSE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            polls_q <= '0;
        end else if (state_q != S_PULSE) begin
            polls_q <= '0;
        end else if (poll_due) begin
            polls_q <= polls_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            clr_q  <= 1'b0;
            err_q  <= ERR_NONE;
        end else begin
            done_q <= fin;
            clr_q  <= clr_req;
            if (start_take) begin
                err_q <= ERR_NONE;
            end else if (fin) begin
                err_q <= fin_err;
            end
        end
    end

    assign prog_n_o     = (state_q != S_PULSE);
    assign busy_o       = (state_q != S_IDLE);
    assign done_o       = done_q;
    assign err_o        = err_q;
    assign clr_sticky_o = clr_q;

    // R2: an accepted start clears the code and requests a sticky clear
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && (err_o == 2'd0) && clr_sticky_o));

    // R4: the program line is released only after INIT was seen low
    p_release_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_n_o) && busy_o) |-> !$past(init_lvl));

    // R5: polling never goes past the limit
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PULSE) |-> (polls_q < POLL_CAP));

    // R8: a successful result comes with a sticky clear
    p_clr_on_success_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (err_o == 2'd0)) |-> clr_sticky_o);

    // R9: done is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: the result is held while idle
    p_err_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_o));

endmodule

// File: tb/sim_pl_reset_seq.sv
module sim_pl_reset_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 100;
    localparam int GAP        = 5;
    localparam int TMO        = 300;
    localparam int NEVER      = 1000000;
    localparam int NV         = 6;

    // fabric behaviour and expected results per vector (-1 = not checked)
    localparam int V_PRE   [NV] = '{1, 0, 1, 0, 1, 1};
    localparam int V_LOW   [NV] = '{3, 3, NEVER, NEVER, 2, 40};
    localparam int V_RISE  [NV] = '{10, 10, NEVER, NEVER, NEVER, 50};
    localparam int V_ERR   [NV] = '{0, 0, 1, 2, 3, 0};
    localparam int V_CLR   [NV] = '{3, 3, 1, 1, 2, 3};
    localparam int V_PLO   [NV] = '{5, 5, LIMIT*GAP, 0, 5, 45};
    localparam int V_PREHI [NV] = '{1, 12, 1, -1, 1, 1};
    localparam int V_BUSY  [NV] = '{18, 29, LIMIT*GAP+1, TMO+1, 1+5+TMO, 98};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       init_i;
    logic       us_tick_i = 1'b1;
    logic       prog_n_o, busy_o, done_o, clr_sticky_o;
    logic [1:0] err_o;

    int checks = 0;
    int errors = 0;

    // fabric model controls
    logic model_ld = 1'b0;
    logic model_en = 1'b0;
    int   pre_lvl  = 0;
    int   low_lat  = NEVER;
    int   rise_lat = NEVER;
    int   lo_cnt   = 0;
    int   hi_cnt   = 0;

    // measurement controls
    logic meas_clr = 1'b0;
    logic meas_en  = 1'b0;
    int   m_busy, m_plo, m_prehi, m_done, m_clr;
    logic m_seen_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    pl_reset_seq #(
        .POLL_LIMIT      (LIMIT),
        .POLL_GAP_US     (GAP),
        .RISE_TIMEOUT_US (TMO),
        .SYNC_STAGES     (2)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .init_i       (init_i),
        .us_tick_i    (us_tick_i),
        .prog_n_o     (prog_n_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .clr_sticky_o (clr_sticky_o)
    );

    // fabric: INIT falls low_lat cycles after the line is pulled low,
    // rises rise_lat cycles after it is released
    always @(negedge clk) begin
        if (model_ld) begin
            init_i <= (pre_lvl != 0);
            lo_cnt = 0;
            hi_cnt = 0;
        end else if (model_en) begin
            if (!prog_n_o) begin
                hi_cnt = 0;
                if (init_i) begin
                    lo_cnt = lo_cnt + 1;
                    if (low_lat != NEVER && lo_cnt >= low_lat) init_i <= 1'b0;
                end
            end else begin
                lo_cnt = 0;
                if (!init_i) begin
                    hi_cnt = hi_cnt + 1;
                    if (rise_lat != NEVER && hi_cnt >= rise_lat) init_i <= 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (meas_clr) begin
            m_busy = 0; m_plo = 0; m_prehi = 0; m_done = 0; m_clr = 0;
            m_seen_low = 1'b0;
        end else if (meas_en) begin
            if (busy_o) m_busy = m_busy + 1;
            if (!prog_n_o) begin
                m_plo = m_plo + 1;
                m_seen_low = 1'b1;
            end
            if (busy_o && prog_n_o && !m_seen_low) m_prehi = m_prehi + 1;
            if (done_o) m_done = m_done + 1;
            if (clr_sticky_o) m_clr = m_clr + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic load_fabric(input int pre, input int lo, input int ri);
        after_edge();
        model_en = 1'b0;
        pre_lvl  = pre;
        low_lat  = lo;
        rise_lat = ri;
        model_ld = 1'b1;
        after_edge();
        model_ld = 1'b0;
        repeat (4) after_edge();
        meas_clr = 1'b1;
        after_edge();
        meas_clr = 1'b0;
        meas_en  = 1'b1;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        after_edge();
        start_i  = 1'b0;
        model_en = 1'b1;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done_o) break;
        end
        repeat (5) @(negedge clk);
        #1;
        meas_en = 1'b0;
    endtask

    task automatic run_vec(input int i, input bit inject);
        load_fabric(V_PRE[i], V_LOW[i], V_RISE[i]);
        pulse_start();
        if (inject) begin
            repeat (20) after_edge();
            start_i = 1'b1;      // R2: must be ignored while busy
            after_edge();
            start_i = 1'b0;
        end
        wait_done();
        // R6 / R5 / R7 result codes
        chk($sformatf("R6/R5/R7 result code v%0d", i), int'(err_o), V_ERR[i]);
        chk($sformatf("R9 single done pulse v%0d", i), m_done, 1);
        chk($sformatf("R8 sticky clear count v%0d", i), m_clr, V_CLR[i]);
        chk($sformatf("R4/R5 program-low cycles v%0d", i), m_plo, V_PLO[i]);
        if (V_PREHI[i] >= 0)
            chk($sformatf("R3 released busy cycles before clear v%0d", i), m_prehi, V_PREHI[i]);
        if (V_BUSY[i] >= 0)
            chk($sformatf("R7 busy cycles v%0d", i), m_busy, V_BUSY[i]);
        @(negedge clk);
        chk($sformatf("R9 idle after run v%0d", i), int'(busy_o), 0);
        chk($sformatf("R9 code held v%0d", i), int'(err_o), V_ERR[i]);
    endtask

    task automatic main_seq();
        // R1: reset state
        pre_lvl  = 0;
        model_ld = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 prog_n in reset", int'(prog_n_o), 1);
        chk("R1 busy in reset", int'(busy_o), 0);
        chk("R1 done in reset", int'(done_o), 0);
        chk("R1 err in reset", int'(err_o), 0);
        chk("R1 clr in reset", int'(clr_sticky_o), 0);
        rst_n = 1'b1;
        model_ld = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'(busy_o), 0);

        // vector table
        for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

        // R2: start while busy ignored (same totals as vector 5)
        run_vec(5, 1'b1);

        // bring code to 3 again, then check that a start clears it
        run_vec(4, 1'b0);

        // R10: no ticks means no timeout
        load_fabric(0, NEVER, NEVER);
        us_tick_i = 1'b0;
        pulse_start();
        @(negedge clk);
        chk("R2 code cleared after start", int'(err_o), 0);
        chk("R8 sticky clear after start", int'(clr_sticky_o), 1);
        chk("R2 busy after start", int'(busy_o), 1);
        repeat (1000) @(negedge clk);
        chk("R10 still busy without ticks", int'(busy_o), 1);
        chk("R10 line released while waiting", int'(prog_n_o), 1);
        chk("R10 no done without ticks", m_done, 0);
        #1;
        us_tick_i = 1'b1;
        wait_done();
        chk("R7 first wait timeout code", int'(err_o), 2);
        chk("R9 single done after stall", m_done, 1);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule